// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Controller

This block moves one data item per descriptor, on its own, whenever an interrupt request it has been armed for goes high. Each interrupt source owns a vector slot in memory. The slot holds the address of a four-word descriptor, and the descriptor says where to read, where to write, how the two addresses move and how many items remain. The controller serves one request at a time, from start to finish. It reads the vector, then loads the descriptor. It reads the data item and writes it to its destination. It then stores the updated addresses and count back into the descriptor. If the descriptor asks for chaining, the controller goes on to the next descriptor in the same activation.

Software arms a source by pulsing its enable-set bit. When the count of the last descriptor in an activation reaches zero, the controller drops that enable bit and the request goes to the processor instead. Otherwise the controller acknowledges the request itself with a one-cycle clear pulse. The controller is the bus master. It sets the length of every access from the address region, and only the external region honours the wait input.

Top module: `irq_xfer_ctrl`

## Requirements
- R1: After reset, busy, mem_req, irq_clr, cpu_irq and every xfer_en bit are 0.
- R2: A source starts an activation only when irq_req, irq_en and xfer_en are all 1 for it. A source with irq_en 0 causes no bus access. A source with irq_en 1 but xfer_en 0 causes no bus access, and its request appears on cpu_irq.
- R3: An activation first reads the word at VEC_BASE + source index. It then reads descriptor words at ptr+0..ptr+3, where ptr is the value read from the vector. Word 0 is the mode, word 1 the source address, word 2 the destination address, and bits [15:0] of word 3 the count.
- R4: For each descriptor, the controller reads one word at the source address and then writes that word unchanged to the destination address.
- R5: Mode bits [1:0] step the source address and bits [3:2] step the destination address: 00 keeps it, 01 adds 1, 10 subtracts 1. The count drops by 1. The controller then writes the source address, destination address and count word (upper half kept) back to ptr+1, ptr+2 and ptr+3, in that order.
- R6: When mode bit 4 is 1, the controller processes the descriptor at ptr+4 in the same activation after the write-back.
- R7: At the end of an activation, if the last count is 0, the source's xfer_en bit clears and its request shows on cpu_irq. Otherwise irq_clr pulses for one cycle for that source and xfer_en stays 1.
- R8: Address bits [15:14] select the region, and mem_req stays high for the access length: 00 gives 1 cycle, 01 gives 1 cycle, 10 gives 2 cycles when mode bit 5 is 0 (byte) or 4 cycles when it is 1 (word), and 11 gives 2 cycles plus every cycle mem_wait is high. mem_wait has no effect in the other regions. At least one idle cycle separates two accesses.
- R9: When several sources are pending together, the lowest index is served first, and only one source is acknowledged at a time.
- R10: busy is 1 from the cycle after a valid request is sampled until the activation's end cycle, and mem_req is only high while busy is 1.
- R11: A pulse on xfer_en_set sets the matching xfer_en bit on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Interrupt request level per source |
| irq_en | input | N_SRC | Interrupt enable per source |
| xfer_en_set | input | N_SRC | Pulse to arm transfers for a source |
| xfer_en | output | N_SRC | Armed-for-transfer state per source |
| irq_clr | output | N_SRC | One-cycle acknowledge of a served request |
| cpu_irq | output | N_SRC | Requests handed to the processor |
| busy | output | 1 | Activation in progress |
| mem_req | output | 1 | Bus access active |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, taken on the access's last cycle |
| mem_wait | input | 1 | Wait request, honoured for the external region only |

## Verification
The bench builds the block with its default parameters: four sources, 16-bit word addresses, 32-bit data, the vector table at address 0, and the default region latencies. With a 16-bit address, the top two bits reach all four regions, so one activation can read from the external region under waits and write to the I/O region as a word. Four sources let requests 0 and 3 arrive in the same cycle to show the priority order. A scoreboard predicts every access's address, direction and length, so the read order, the chaining, the write-back order and the region timing are all checked on each access.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_VEC,
    S_DESC,
    S_RD,
    S_WR,
    S_WB,
    S_FIN
  } xfer_state_e;

  localparam int unsigned MODE_W         = 8;
  localparam int unsigned MODE_CHAIN_BIT = 4;
  localparam int unsigned MODE_WORD_BIT  = 5;

  localparam logic [1:0] STEP_INC = 2'b01;
  localparam logic [1:0] STEP_DEC = 2'b10;

  localparam logic [1:0] REG_RAM = 2'b00;
  localparam logic [1:0] REG_ROM = 2'b01;
  localparam logic [1:0] REG_IO  = 2'b10;

endpackage

// File: rtl/xfer_region_lat.sv
module xfer_region_lat
  import xfer_pkg::*;
#(
  parameter logic [2:0] LAT_RAM  = 3'd1,
  parameter logic [2:0] LAT_ROM  = 3'd1,
  parameter logic [2:0] LAT_IO_B = 3'd2,
  parameter logic [2:0] LAT_IO_W = 3'd4,
  parameter logic [2:0] LAT_EXT  = 3'd2
) (
  input  logic [1:0] region,
  input  logic       word,
  output logic [2:0] lat,
  output logic       ext
);

  always_comb begin
    ext = 1'b0;
    unique case (region)
      REG_RAM: lat = LAT_RAM;
      REG_ROM: lat = LAT_ROM;
      REG_IO:  lat = word ? LAT_IO_W : LAT_IO_B;
      default: begin
        lat = LAT_EXT;
        ext = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/xfer_bus_port.sv
module xfer_bus_port #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] st_addr,
  input  logic          st_we,
  input  logic          st_word,
  input  logic [DW-1:0] st_wdata,
  input  logic          mem_wait,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          done
);

  logic          req_q, req_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [2:0]    lat_q, lat_d;
  logic          ext_q, ext_d;
  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [2:0]    lat_dec;
  logic          ext_dec;
  logic          stall;

  xfer_region_lat u_region (
    .region (st_addr[AW-1 -: 2]),
    .word   (st_word),
    .lat    (lat_dec),
    .ext    (ext_dec)
  );

  assign stall = ext_q && mem_wait;
  assign done  = req_q && !stall && (cnt_q == lat_q - 3'd1);

  always_comb begin
    req_d   = req_q;
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    ext_d   = ext_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (start) begin
      req_d   = 1'b1;
      cnt_d   = 3'd0;
      lat_d   = lat_dec;
      ext_d   = ext_dec;
      we_d    = st_we;
      addr_d  = st_addr;
      wdata_d = st_wdata;
    end else if (req_q) begin
      if (done) begin
        req_d = 1'b0;
      end else if (!stall) begin
        cnt_d = cnt_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cnt_q   <= '0;
      lat_q   <= 3'd1;
      ext_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      req_q   <= req_d;
      cnt_q   <= cnt_d;
      lat_q   <= lat_d;
      ext_q   <= ext_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

endmodule

// File: rtl/xfer_prio_pick.sv
module xfer_prio_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned SW = 2
) (
  input  logic [N-1:0]  req,
  output logic [SW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = SW'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_xfer_ctrl.sv
module irq_xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  input  logic [N_SRC-1:0] xfer_en_set,
  output logic [N_SRC-1:0] xfer_en,
  output logic [N_SRC-1:0] irq_clr,
  output logic [N_SRC-1:0] cpu_irq,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_wait
);

  localparam int unsigned SW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned CW = DW / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  xfer_state_e       st_q, st_d;
  logic [SW-1:0]     src_q, src_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic [1:0]        idx_q, idx_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [AW-1:0]     sar_q, sar_d;
  logic [AW-1:0]     dar_q, dar_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CW-1:0]     cnth_q, cnth_d;
  logic [DW-1:0]     data_q, data_d;
  logic [N_SRC-1:0]  en_q, en_d, en_clr;
  logic              issued_q, issued_d;

  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata;
  logic          acc_we, acc_word, acc_on, start, done;
  logic [SW-1:0] pick_idx;
  logic          pick_any;

  function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a, logic [1:0] m);
    if (m == STEP_INC)      return a + AW'(1);
    else if (m == STEP_DEC) return a - AW'(1);
    else                    return a;
  endfunction

  xfer_prio_pick #(.N(N_SRC), .SW(SW)) u_pick (
    .req (irq_req & irq_en & en_q),
    .idx (pick_idx),
    .any (pick_any)
  );

  xfer_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst_n     (rst_ni),
    .start     (start),
    .st_addr   (acc_addr),
    .st_we     (acc_we),
    .st_word   (acc_word),
    .st_wdata  (acc_wdata),
    .mem_wait  (mem_wait),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done)
  );

  assign acc_on   = (st_q != S_IDLE) && (st_q != S_FIN);
  assign start    = acc_on && !issued_q;
  assign issued_d = done ? 1'b0 : (start ? 1'b1 : issued_q);

  always_comb begin
    st_d = st_q;  src_d = src_q;  ptr_d = ptr_q;  idx_d = idx_q;
    mode_d = mode_q;  sar_d = sar_q;  dar_d = dar_q;
    cnt_d = cnt_q;  cnth_d = cnth_q;  data_d = data_q;
    en_clr = '0;  irq_clr = '0;
    acc_addr = '0;  acc_we = 1'b0;  acc_word = 1'b1;  acc_wdata = '0;
    unique case (st_q)
      S_IDLE: if (pick_any) begin
        src_d = pick_idx;
        st_d  = S_VEC;
      end
      S_VEC: begin
        acc_addr = VEC_BASE + AW'(src_q);
        if (done) begin
          ptr_d = mem_rdata[AW-1:0];
          idx_d = 2'd0;
          st_d  = S_DESC;
        end
      end
      S_DESC: begin
        acc_addr = ptr_q + AW'(idx_q);
        if (done) begin
          unique case (idx_q)
            2'd0: mode_d = mem_rdata[MODE_W-1:0];
            2'd1: sar_d  = mem_rdata[AW-1:0];
            2'd2: dar_d  = mem_rdata[AW-1:0];
            default: begin
              cnt_d  = mem_rdata[CW-1:0];
              cnth_d = mem_rdata[DW-1:CW];
            end
          endcase
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd3) st_d = S_RD;
        end
      end
      S_RD: begin
        acc_addr = sar_q;
        acc_word = mode_q[MODE_WORD_BIT];
        if (done) begin
          data_d = mem_rdata;
          st_d   = S_WR;
        end
      end
      S_WR: begin
        acc_addr  = dar_q;
        acc_we    = 1'b1;
        acc_word  = mode_q[MODE_WORD_BIT];
        acc_wdata = data_q;
        if (done) begin
          sar_d = step_addr(sar_q, mode_q[1:0]);
          dar_d = step_addr(dar_q, mode_q[3:2]);
          cnt_d = cnt_q - CW'(1);
          idx_d = 2'd0;
          st_d  = S_WB;
        end
      end
      S_WB: begin
        acc_addr = ptr_q + AW'(idx_q) + AW'(1);
        acc_we   = 1'b1;
        unique case (idx_q)
          2'd0:    acc_wdata = DW'(sar_q);
          2'd1:    acc_wdata = DW'(dar_q);
          default: acc_wdata = {cnth_q, cnt_q};
        endcase
        if (done) begin
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd2) begin
            if (mode_q[MODE_CHAIN_BIT]) begin
              ptr_d = ptr_q + AW'(4);
              idx_d = 2'd0;
              st_d  = S_DESC;
            end else begin
              st_d = S_FIN;
            end
          end
        end
      end
      default: begin
        if (cnt_q == '0) en_clr[src_q]  = 1'b1;
        else             irq_clr[src_q] = 1'b1;
        st_d = S_IDLE;
      end
    endcase
  end

  assign en_d = (en_q & ~en_clr) | xfer_en_set;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  src_q <= '0;  ptr_q <= '0;  idx_q <= '0;
      mode_q <= '0;  sar_q <= '0;  dar_q <= '0;  cnt_q <= '0;
      cnth_q <= '0;  data_q <= '0;  en_q <= '0;  issued_q <= 1'b0;
    end else begin
      st_q <= st_d;  src_q <= src_d;  ptr_q <= ptr_d;  idx_q <= idx_d;
      mode_q <= mode_d;  sar_q <= sar_d;  dar_q <= dar_d;  cnt_q <= cnt_d;
      cnth_q <= cnth_d;  data_q <= data_d;  en_q <= en_d;  issued_q <= issued_d;
    end
  end

  assign xfer_en = en_q;
  assign cpu_irq = irq_req & irq_en & ~en_q;
  assign busy    = (st_q != S_IDLE);

endmodule

// File: rtl/irq_xfer_ctrl_chk.sv
module irq_xfer_ctrl_chk #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned AW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic [N_SRC-1:0] irq_clr,
  input logic [N_SRC-1:0] xfer_en
);

  logic [7:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (!mem_req)     run_q <= '0;
    else if (run_q != '1)  run_q <= run_q + 8'd1;
  end

  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy) else $error("bus access outside activation"); // R10

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr)) else $error("address moved in access"); // R4

  AST_INT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_addr[AW-1 -: 2] != 2'b11) |-> (run_q < 8'd4)) else $error("internal access too long"); // R8

  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_clr)) else $error("several acknowledges"); // R9

  AST_ACK_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_clr) |-> busy) else $error("acknowledge while idle"); // R7

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    AST_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_en[i]) |-> $past(busy)) else $error("enable cleared outside activation"); // R7
  end

endmodule

bind irq_xfer_ctrl irq_xfer_ctrl_chk #(.N_SRC(N_SRC), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .irq_clr  (irq_clr),
  .xfer_en  (xfer_en)
);

// File: tb/irq_xfer_ctrl_tb_top.sv
module irq_xfer_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_req, irq_en, xfer_en_set;
  logic [N-1:0]  xfer_en, irq_clr, cpu_irq;
  logic          busy, mem_req, mem_we, mem_wait;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_xfer_ctrl #(.N_SRC(N), .AW(AW), .DW(DW)) dut_i (
    .clk, .rst_n, .irq_req, .irq_en, .xfer_en_set, .xfer_en, .irq_clr,
    .cpu_irq, .busy, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata, .mem_wait
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        we;
    logic [7:0]  len;
  } acc_t;

  acc_t        exp_q[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  int          waits   = 0;
  logic [31:0] mem [256];
  logic [7:0]  req_age = '0;
  logic [N-1:0] clr_seen;

  // memory model: region bits plus six low bits index a small array
  assign mem_rdata = mem[{mem_addr[15:14], mem_addr[5:0]}];
  assign mem_wait  = mem_req && (int'(req_age) < waits);

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[{mem_addr[15:14], mem_addr[5:0]}] = mem_wdata;
    req_age <= mem_req ? req_age + 8'd1 : 8'd0;
  end

  function automatic logic [31:0] rd(logic [15:0] a);
    return mem[{a[15:14], a[5:0]}];
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    mem[{a[15:14], a[5:0]}] = d;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lat(logic [15:0] a, bit word);
    case (a[15:14])
      2'b00, 2'b01: return 1;
      2'b10:        return word ? 4 : 2;
      default:      return 2 + waits;
    endcase
  endfunction

  // driver side of the scoreboard
  task automatic push(logic [15:0] a, bit we, int len);
    acc_t e;
    e.addr = a; e.we = we; e.len = 8'(len);
    exp_q.push_back(e);
  endtask

  task automatic plan_vec(int src);
    push(16'(src), 1'b0, 1);
  endtask

  task automatic plan_desc(logic [15:0] ptr, logic [15:0] sar, logic [15:0] dar, bit word);
    for (int k = 0; k < 4; k++) push(ptr + 16'(k), 1'b0, lat(ptr + 16'(k), 1'b1));
    push(sar, 1'b0, lat(sar, word));
    push(dar, 1'b1, lat(dar, word));
    for (int k = 1; k < 4; k++) push(ptr + 16'(k), 1'b1, 1);
  endtask

  // monitor side: one completed access per falling mem_req
  int          run = 0;
  logic [15:0] cur_addr;
  logic        cur_we;
  always @(negedge clk) begin
    if (mem_req) begin
      if (run == 0) begin
        cur_addr = mem_addr;
        cur_we   = mem_we;
      end
      run++;
    end else if (run > 0) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R3: unexpected access actual %h expected none", cur_addr);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        check("R3 access address", 32'(cur_addr), 32'(e.addr));
        check("R4 access direction", 32'(cur_we), 32'(e.we));
        check("R8 access length", 32'(run), 32'(e.len));
      end
      run = 0;
    end
    for (int i = 0; i < N; i++) begin
      if (irq_clr[i]) begin
        irq_req[i]  = 1'b0;
        clr_seen[i] = 1'b1;
      end
    end
  end

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic quiet_window(string tag);
    int acts = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (mem_req || busy) acts++;
    end
    check(tag, 32'(acts), 32'd0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    irq_req = '0; irq_en = '0; xfer_en_set = '0; clr_seen = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 busy", 32'(busy), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 xfer_en", 32'(xfer_en), 0);
    check("R1 cpu_irq", 32'(cpu_irq), 0);
    check("R1 irq_clr", 32'(irq_clr), 0);

    // vectors and descriptors
    wr(16'h0000, 32'h10); wr(16'h0001, 32'h14); wr(16'h0002, 32'h18); wr(16'h0003, 32'h20);
    wr(16'h0010, 32'h25); wr(16'h0011, 32'h30);   wr(16'h0012, 32'h38);   wr(16'h0013, 32'h0007_0002);
    wr(16'h0014, 32'h02); wr(16'h0015, 32'h4005); wr(16'h0016, 32'h8002); wr(16'h0017, 32'h1);
    wr(16'h0018, 32'h35); wr(16'h0019, 32'hC000); wr(16'h001A, 32'h34);   wr(16'h001B, 32'h3);
    wr(16'h001C, 32'h28); wr(16'h001D, 32'h31);   wr(16'h001E, 32'h8010); wr(16'h001F, 32'h5);
    wr(16'h0020, 32'h25); wr(16'h0021, 32'h3A);   wr(16'h0022, 32'h3B);   wr(16'h0023, 32'h4);
    wr(16'h0030, 32'hA5A5_0001); wr(16'h4005, 32'h5A); wr(16'hC000, 32'h1111_2222);
    wr(16'h0031, 32'h3333_4444); wr(16'h003A, 32'hDEAD_0003);
    irq_en = 4'b1111;

    xfer_en_set = 4'b1101;
    @(negedge clk);
    xfer_en_set = '0;
    check("R11 enable set", 32'(xfer_en), 32'b1101);

    // T1: RAM to RAM, both increment, count 2 -> 1; waits ignored internally
    waits = 3;
    plan_vec(0);
    plan_desc(16'h0010, 16'h0030, 16'h0038, 1'b1);
    irq_req[0] = 1'b1;
    @(negedge clk);
    check("R10 busy after request", 32'(busy), 1);
    wait_idle();
    check("R4 data moved", rd(16'h0038), 32'hA5A5_0001);
    check("R5 source written back", rd(16'h0011), 32'h31);
    check("R5 dest written back", rd(16'h0012), 32'h39);
    check("R5 count written back", rd(16'h0013), 32'h0007_0001);
    check("R7 acknowledge pulse", 32'(clr_seen[0]), 1);
    check("R7 enable kept", 32'(xfer_en[0]), 1);
    check("R7 no cpu request", 32'(cpu_irq[0]), 0);

    // T2: ROM byte to I/O byte, source decrements, last item
    waits = 0;
    xfer_en_set = 4'b0010;
    @(negedge clk);
    xfer_en_set = '0;
    plan_vec(1);
    plan_desc(16'h0014, 16'h4005, 16'h8002, 1'b0);
    irq_req[1] = 1'b1;
    wait_idle();
    check("R4 ROM to I/O data", rd(16'h8002), 32'h5A);
    check("R5 source decremented", rd(16'h0015), 32'h4004);
    check("R5 dest held", rd(16'h0016), 32'h8002);
    check("R5 count zero", rd(16'h0017), 32'h0);
    check("R7 enable cleared", 32'(xfer_en[1]), 0);
    check("R7 request to cpu", 32'(cpu_irq[1]), 1);
    check("R7 no acknowledge", 32'(clr_seen[1]), 0);
    quiet_window("R2 disarmed source idle");
    irq_req[1] = 1'b0;

    // T3: chained pair, external source under waits, I/O word destination
    waits = 3;
    plan_vec(2);
    plan_desc(16'h0018, 16'hC000, 16'h0034, 1'b1);
    plan_desc(16'h001C, 16'h0031, 16'h8010, 1'b1);
    irq_req[2] = 1'b1;
    wait_idle();
    check("R6 first item", rd(16'h0034), 32'h1111_2222);
    check("R6 second item", rd(16'h8010), 32'h3333_4444);
    check("R5 first source", rd(16'h0019), 32'hC001);
    check("R5 first dest", rd(16'h001A), 32'h35);
    check("R5 first count", rd(16'h001B), 32'h2);
    check("R5 second source held", rd(16'h001D), 32'h31);
    check("R5 second dest decremented", rd(16'h001E), 32'h800F);
    check("R6 second count", rd(16'h001F), 32'h4);
    check("R7 chain acknowledged", 32'(clr_seen[2]), 1);

    // T4: sources 0 and 3 together, lowest first
    waits = 0;
    clr_seen = '0;
    plan_vec(0);
    plan_desc(16'h0010, 16'h0031, 16'h0039, 1'b1);
    plan_vec(3);
    plan_desc(16'h0020, 16'h003A, 16'h003B, 1'b1);
    irq_req[0] = 1'b1;
    irq_req[3] = 1'b1;
    wait_idle();
    check("R9 source 0 data", rd(16'h0039), 32'h3333_4444);
    check("R9 source 3 data", rd(16'h003B), 32'hDEAD_0003);
    check("R7 source 0 exhausted", 32'(xfer_en[0]), 0);
    check("R7 source 0 to cpu", 32'(cpu_irq[0]), 1);
    check("R9 source 3 acknowledged", 32'(clr_seen[3]), 1);
    check("R5 upper count kept", rd(16'h0013), 32'h0007_0000);
    irq_req[0] = 1'b0;

    // T5: armed source with interrupt disabled
    irq_en[3] = 1'b0;
    irq_req[3] = 1'b1;
    quiet_window("R2 masked source idle");
    check("R2 masked no cpu request", 32'(cpu_irq[3]), 0);
    irq_req[3] = 1'b0;
    @(negedge clk);

    check("R3 all accesses seen", 32'(exp_q.size()), 0);
    summary();
  end

endmodule